// File: doc/BRIEF.md
# Serial Codec Bus Timing Master

This block is the timing master for a four-wire serial codec bus of the IOM kind. It runs from a 7.68 MHz master clock and divides it by five to make the bus data clock. It also makes a bit clock at half that rate and a frame sync that marks the start of every 125 us frame. A frame holds 96 bit periods, which is 12 eight-bit time slots. Up to eight devices share these slots.

Two strobe outputs can be set up independently, each with a slot index and an enable. Each strobe marks its chosen eight-bit slot for a codec on the bus. The block also handles the serial data bits for the framing logic next to it:
- An outgoing bit is launched at the rising data-clock edge that opens each bit period.
- An incoming bit is captured at the falling data-clock edge in the second half of the bit, and a one-cycle valid pulse goes with it.

The running bit and slot counters are brought out so that the framing logic can place channel content.

Top module: `gci_bus_timer`

## Requirements
- R1: While `rstN` is low, `dclOut`, `bclOut`, `fscOut`, `strobeOut`, `serOut`, `rxBit` and `rxValid` are 0, and `bitCount` and `slotCount` are 0.
- R2: `dclOut` repeats every 5 master cycles: high for 3 cycles, then low for 2. Its first high cycle is the first cycle after reset is released.
- R3: `bclOut` repeats every 10 master cycles. It is high during the first data-clock period of each bit and rises in the same cycle as `dclOut`.
- R4: `fscOut` is high for the first 5 master cycles of each 960-cycle frame.
- R5: `bitCount` counts 0 to 95 and steps every 10 master cycles. `slotCount` equals `bitCount` divided by 8, rounded down (0 to 11).
- R6: Strobe k is high exactly while `strobeEn[k]` is 1 and `slotCount` equals `strobeSlot[k]`. That is 80 master cycles per frame.
- R7: A strobe whose enable is 0, or whose slot index is 12 to 15, stays low for the whole frame.
- R8: `serOut` takes the value of `txBit` at the clock edge that begins each bit period, which is where `dclOut` rises together with `bclOut`. It holds that value for 10 master cycles.
- R9: `serIn` is captured into `rxBit` at the clock edge where `dclOut` falls in the second data-clock period of a bit. `rxValid` is high for the one cycle that follows this edge.
- R10: The two strobes are independent. Both may select the same slot, and then both are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7.68 MHz master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txBit | input | 1 | Next outgoing bit, taken at the start of each bit period |
| serIn | input | 1 | Incoming serial data |
| strobeSlot | input | 2x4 | Slot index for each strobe |
| strobeEn | input | 2 | Enable for each strobe |
| dclOut | output | 1 | Data clock, master divided by 5 |
| bclOut | output | 1 | Bit clock, data clock divided by 2 |
| fscOut | output | 1 | Frame sync |
| bitCount | output | 7 | Bit index within the frame |
| slotCount | output | 4 | Time-slot index within the frame |
| strobeOut | output | 2 | Slot strobes |
| serOut | output | 1 | Outgoing serial data |
| rxBit | output | 1 | Last captured incoming bit |
| rxValid | output | 1 | One-cycle pulse after each capture |

## Verification
The assertions assume the following about the inputs:
- Reset is asserted asynchronously.
- Strobe settings and data inputs do not change at a rising master edge.
- A strobe setting may be changed at any point in a frame, and the strobes follow the new setting at once.

The stimulus changes every input 1 ns after a rising edge, and it rewrites the strobe settings in the middle of frames. The settings it uses include equal slots, a disabled strobe and an index above 11. It also asserts reset again partway through a frame, which checks that the frame restarts cleanly.

// File: rtl/gci_timer_pkg.sv
package gci_timer_pkg;
  // Per-cycle control strobes passed from the counter block to the datapath
  typedef struct packed {
    logic run;       // counters are advancing
    logic loadTx;    // this edge opens a bit period
    logic sampleRx;  // this edge is the second-half falling data-clock edge
  } tickCtl_t;
endpackage

// File: rtl/gci_timer_ctrl.sv
module gci_timer_ctrl
  import gci_timer_pkg::*;
#(
  parameter int DIV           = 5,
  parameter int DCL_PER_FRAME = 192,
  parameter int HIGH_PH       = 3,
  localparam int PH_W  = $clog2(DIV),
  localparam int DCL_W = $clog2(DCL_PER_FRAME)
) (
  input  logic             clk,
  input  logic             rstN,
  output tickCtl_t         ctl,
  output logic [PH_W-1:0]  phase,
  output logic [DCL_W-1:0] dclCnt
);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(DIV - 1);
  localparam logic [DCL_W-1:0] DCL_LAST = DCL_W'(DCL_PER_FRAME - 1);
  localparam logic [PH_W-1:0]  PH_FALL  = PH_W'(HIGH_PH);

  logic             runQ;
  logic [PH_W-1:0]  phaseQ, phaseNext;
  logic [DCL_W-1:0] dclQ, dclNext;

  always_comb begin
    if (!runQ) begin
      phaseNext = '0;
      dclNext   = '0;
    end else if (phaseQ == PH_LAST) begin
      phaseNext = '0;
      dclNext   = (dclQ == DCL_LAST) ? '0 : dclQ + 1'b1;
    end else begin
      phaseNext = phaseQ + 1'b1;
      dclNext   = dclQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      phaseQ <= '0;
      dclQ   <= '0;
    end else begin
      runQ   <= 1'b1;
      phaseQ <= phaseNext;
      dclQ   <= dclNext;
    end
  end

  always_comb begin
    ctl.run      = runQ;
    ctl.loadTx   = (phaseNext == '0) && !dclNext[0];
    ctl.sampleRx = (phaseNext == PH_FALL) && dclNext[0];
  end

  assign phase  = phaseQ;
  assign dclCnt = dclQ;

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && phaseQ == PH_LAST) |=> (phaseQ == '0));

  // R4
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && phaseQ == PH_LAST && dclQ == DCL_LAST) |=> (dclQ == '0));
endmodule

// File: rtl/gci_timer_dp.sv
module gci_timer_dp
  import gci_timer_pkg::*;
#(
  parameter int SLOTS       = 12,
  parameter int SLOT_BITS   = 8,
  parameter int SLOT_IDX_W  = 4,
  parameter int NUM_STROBES = 2,
  parameter int DIV         = 5,
  parameter int HIGH_PH     = 3,
  localparam int PH_W  = $clog2(DIV),
  localparam int DCL_W = $clog2(2 * SLOTS * SLOT_BITS),
  localparam int BIT_W = $clog2(SLOTS * SLOT_BITS)
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  tickCtl_t                               ctl,
  input  logic [PH_W-1:0]                        phase,
  input  logic [DCL_W-1:0]                       dclCnt,
  input  logic                                   txBit,
  input  logic                                   serIn,
  input  logic [NUM_STROBES-1:0][SLOT_IDX_W-1:0] strobeSlot,
  input  logic [NUM_STROBES-1:0]                 strobeEn,
  output logic                                   dclOut,
  output logic                                   bclOut,
  output logic                                   fscOut,
  output logic [BIT_W-1:0]                       bitCount,
  output logic [SLOT_IDX_W-1:0]                  slotCount,
  output logic [NUM_STROBES-1:0]                 strobeOut,
  output logic                                   serOut,
  output logic                                   rxBit,
  output logic                                   rxValid
);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HIGH_PH);
  localparam int DCL_PER_SLOT = 2 * SLOT_BITS;

  always_comb begin
    dclOut    = ctl.run && (phase < PH_HIGH);
    bclOut    = ctl.run && !dclCnt[0];
    fscOut    = ctl.run && (dclCnt == '0);
    bitCount  = BIT_W'(dclCnt >> 1);
    slotCount = SLOT_IDX_W'(int'(dclCnt) / DCL_PER_SLOT);
  end

  for (genvar k = 0; k < NUM_STROBES; k++) begin : g_strobe
    assign strobeOut[k] = ctl.run && strobeEn[k] && (strobeSlot[k] == slotCount);

    // R7
    strobe_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobeOut[k] |-> (strobeEn[k] && (int'(strobeSlot[k]) < SLOTS)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serOut  <= 1'b0;
      rxBit   <= 1'b0;
      rxValid <= 1'b0;
    end else begin
      if (ctl.loadTx) serOut <= txBit;
      if (ctl.sampleRx) rxBit <= serIn;
      rxValid <= ctl.sampleRx;
    end
  end

  // R3
  bcl_with_dcl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bclOut) |-> $rose(dclOut));

  // R4
  fsc_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fscOut) |-> (dclOut && bitCount == '0));

  // R8
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadTx |=> $stable(serOut));

  // R9
  rx_second_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (!dclOut && !bclOut));
endmodule

// File: rtl/gci_bus_timer.sv
module gci_bus_timer
  import gci_timer_pkg::*;
#(
  parameter int DIV         = 5,
  parameter int SLOTS       = 12,
  parameter int SLOT_BITS   = 8,
  parameter int SLOT_IDX_W  = 4,
  parameter int NUM_STROBES = 2,
  localparam int BIT_W = $clog2(SLOTS * SLOT_BITS)
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   txBit,
  input  logic                                   serIn,
  input  logic [NUM_STROBES-1:0][SLOT_IDX_W-1:0] strobeSlot,
  input  logic [NUM_STROBES-1:0]                 strobeEn,
  output logic                                   dclOut,
  output logic                                   bclOut,
  output logic                                   fscOut,
  output logic [BIT_W-1:0]                       bitCount,
  output logic [SLOT_IDX_W-1:0]                  slotCount,
  output logic [NUM_STROBES-1:0]                 strobeOut,
  output logic                                   serOut,
  output logic                                   rxBit,
  output logic                                   rxValid
);
  localparam int DCL_PER_FRAME = 2 * SLOTS * SLOT_BITS;
  localparam int HIGH_PH       = (DIV + 1) / 2;
  localparam int PH_W          = $clog2(DIV);
  localparam int DCL_W         = $clog2(DCL_PER_FRAME);

  tickCtl_t         ctl;
  logic [PH_W-1:0]  phase;
  logic [DCL_W-1:0] dclCnt;

  gci_timer_ctrl #(
    .DIV(DIV), .DCL_PER_FRAME(DCL_PER_FRAME), .HIGH_PH(HIGH_PH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctl(ctl), .phase(phase), .dclCnt(dclCnt)
  );

  gci_timer_dp #(
    .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .SLOT_IDX_W(SLOT_IDX_W),
    .NUM_STROBES(NUM_STROBES), .DIV(DIV), .HIGH_PH(HIGH_PH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .phase(phase), .dclCnt(dclCnt),
    .txBit(txBit), .serIn(serIn), .strobeSlot(strobeSlot), .strobeEn(strobeEn),
    .dclOut(dclOut), .bclOut(bclOut), .fscOut(fscOut), .bitCount(bitCount),
    .slotCount(slotCount), .strobeOut(strobeOut), .serOut(serOut),
    .rxBit(rxBit), .rxValid(rxValid)
  );
endmodule

// File: tb/gci_bus_timer_test.sv
module gci_bus_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txBit = 1'b0;
  logic serIn = 1'b0;
  logic [1:0][3:0] strobeSlot = '0;
  logic [1:0] strobeEn = '0;
  logic dclOut, bclOut, fscOut, serOut, rxBit, rxValid;
  logic [6:0] bitCount;
  logic [3:0] slotCount;
  logic [1:0] strobeOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int  mt = 0;
  bit  running = 0;
  int  expSer = 0, expRx = 0, expRxV = 0;
  logic [15:0] lfsrA = 16'hACE1, lfsrB = 16'h1D2B;

  gci_bus_timer uut (
    .clk(clk), .rstN(rstN), .txBit(txBit), .serIn(serIn),
    .strobeSlot(strobeSlot), .strobeEn(strobeEn), .dclOut(dclOut),
    .bclOut(bclOut), .fscOut(fscOut), .bitCount(bitCount),
    .slotCount(slotCount), .strobeOut(strobeOut), .serOut(serOut),
    .rxBit(rxBit), .rxValid(rxValid)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      running = 0; mt = 0; expSer = 0; expRx = 0; expRxV = 0;
    end else begin
      if (running) mt = (mt + 1) % 960;
      else running = 1;
      if (mt % 10 == 0) expSer = txBit;
      expRxV = (mt % 10 == 8) ? 1 : 0;
      if (expRxV == 1) expRx = serIn;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      chk("R1 clocks", {29'd0, dclOut, bclOut, fscOut}, 0);
      chk("R1 counters", {bitCount, slotCount}, 0);
      chk("R1 strobes/data", {27'd0, strobeOut, serOut, rxBit, rxValid}, 0);
    end else begin
      chk("R2 dcl", dclOut, (running && mt % 5 < 3) ? 1 : 0);
      chk("R3 bcl", bclOut, (running && mt % 10 < 5) ? 1 : 0);
      chk("R4 fsc", fscOut, (running && mt < 5) ? 1 : 0);
      chk("R5 bitCount", bitCount, mt / 10);
      chk("R5 slotCount", slotCount, mt / 80);
      for (int k = 0; k < 2; k++) begin
        int exp;
        exp = (running && strobeEn[k] && int'(strobeSlot[k]) == mt / 80) ? 1 : 0;
        if (!strobeEn[k] || strobeSlot[k] > 4'd11) chk("R7 strobe off", strobeOut[k], exp);
        else if (strobeEn == 2'b11 && strobeSlot[0] == strobeSlot[1])
          chk("R10 shared slot", strobeOut[k], exp);
        else chk("R6 strobe", strobeOut[k], exp);
      end
      chk("R8 serOut", serOut, expSer);
      chk("R9 rxBit", rxBit, expRx);
      chk("R9 rxValid", rxValid, expRxV);
    end
  end

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      lfsrA = {lfsrA[14:0], lfsrA[15] ^ lfsrA[13] ^ lfsrA[12] ^ lfsrA[10]};
      lfsrB = {lfsrB[14:0], lfsrB[15] ^ lfsrB[13] ^ lfsrB[12] ^ lfsrB[10]};
      txBit = lfsrA[0];
      serIn = lfsrB[3];
    end
  endtask

  initial begin
    strobeSlot[0] = 4'd0;  strobeEn[0] = 1'b1;
    strobeSlot[1] = 4'd11; strobeEn[1] = 1'b1;
    runCycles(4);
    rstN = 1'b1;                       // released 1 ns after an edge
    runCycles(1000);
    strobeSlot[0] = 4'd5; strobeSlot[1] = 4'd5;   // R10
    runCycles(1000);
    strobeEn[0] = 1'b0; strobeSlot[1] = 4'd13;    // R7
    runCycles(1000);
    rstN = 1'b0;                                   // mid-frame reset, R1
    runCycles(3);
    strobeSlot[0] = 4'd3; strobeEn[0] = 1'b1;
    strobeSlot[1] = 4'd11;
    rstN = 1'b1;
    runCycles(1200);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule